// File: doc/BRIEF.md
# Configuration Data Width and Clock-Ratio Adapter

This block sits between a register-bus data port and the configuration pins of a programmable device. Software pushes whole 32-bit words into it through a valid/ready stream. Each word is presented to the device as a single 32-bit unit, or as two 16-bit units. Every unit stays on the data pins for a programmable number of configuration clock pulses.

A mode bit sets the unit width. A two-bit ratio field sets the pulses per unit. Modes that decrypt or decompress inside the device need more clocks per data unit than plain modes, and that is the only way those features affect this block. The stream accepts a word only while the bus-side configuration enable is set. The input stays not-ready until every pulse of the current word has been produced.

Each pulse takes two cycles of the system clock: one with the device clock low and one with it high. Data only changes as the device clock falls, so it is settled at every rising edge.

Top module: `cfg_width_adapter`

## Requirements
- R1: While rst_n is low, dev_clk is 0 and dev_data is all zeros; after reset the block is idle.
- R2: wr_ready is 1 only while bus_cfg_en is 1 and no word is in progress. With bus_cfg_en at 0, an offered word is not taken: dev_clk stays 0 and dev_data keeps its value.
- R3: With wide_mode = 1 at acceptance, the word appears on dev_data as one 32-bit unit.
- R4: With wide_mode = 0 at acceptance, the word is sent as two units: first bits 15:0, then bits 31:16. Each unit sits on dev_data[15:0] with dev_data[31:16] driven to zero.
- R5: clk_ratio encodes the rising edges of dev_clk per unit: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8.
- R6: Each dev_clk pulse is one cycle high followed by one cycle low. dev_data is unchanged in every cycle in which dev_clk is high.
- R7: wr_ready is low for exactly 2 × pulses-per-unit × unit-count cycles after the accepting clock edge.
- R8: wide_mode and clk_ratio are captured when a word is accepted. Changing them while the word is in progress does not alter that word.
- R9: Clearing bus_cfg_en while a word is in progress does not cut the word short; it only blocks the next one.
- R10: When a word completes, dev_clk rests at 0 and dev_data keeps the last unit until the next word is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_cfg_en | input | 1 | Bus configuration enable; gates word acceptance |
| wide_mode | input | 1 | 1: 32-bit units, 0: 16-bit units (captured per word) |
| clk_ratio | input | 2 | Pulses per unit encoded as 1 << clk_ratio (captured per word) |
| wr_valid | input | 1 | A data word is offered |
| wr_data | input | 32 | Offered data word |
| wr_ready | output | 1 | The block takes the word at this clock edge if wr_valid is 1 |
| dev_clk | output | 1 | Configuration clock to the device |
| dev_data | output | 32 | Configuration data to the device |

## Verification
Two events can land on the same edge. One is the switch from the low half-word to the high half-word, or the final falling edge of a word. The other is a change on wide_mode, clk_ratio or bus_cfg_en that is meant for the next word. The bench flips the settings, or drops the enable, in the cycle after acceptance and keeps them changed through the whole word. It then checks three things: the pulse count and unit values follow the captured settings, the unit order is unchanged, and wr_ready returns only as the enable allows. Random words with random width and ratio are also checked unit by unit at every rising dev_clk edge, against values the bench computes from the requirements.

// File: rtl/cda_pkg.sv
`timescale 1ns/1ps
package cda_pkg;

  // Phase of the transfer sequencer
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOW  = 2'd1,
    SEQ_HIGH = 2'd2
  } seq_state_e;

endpackage

// File: rtl/cda_sequencer.sv
`timescale 1ns/1ps
module cda_sequencer
  import cda_pkg::*;
#(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_cfg_en,
  input  logic               wr_valid,
  input  logic               wide_mode,
  input  logic [RATIO_W-1:0] clk_ratio,
  output logic               wr_ready,
  output logic               load_o,
  output logic               adv_o,
  output logic               busy_o,
  output seq_state_e         state_next_o
);

  localparam int MAX_SHIFT = (1 << RATIO_W) - 1;
  localparam int CNT_W     = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

  seq_state_e         state_q, state_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               unit_q, unit_n;
  logic               wide_q, wide_n;
  logic [RATIO_W-1:0] ratio_q, ratio_n;
  logic [CNT_W-1:0]   last_idx;
  logic               last_pulse;
  logic               last_unit;
  logic               accept;

  // Index of the final pulse of a unit: (1 << ratio) - 1
  always_comb begin
    last_idx = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(ratio_q)) last_idx[i] = 1'b1;
    end
  end

  assign last_pulse = (cnt_q == last_idx);
  assign last_unit  = wide_q | unit_q;
  assign wr_ready   = bus_cfg_en & (state_q == SEQ_IDLE);
  assign accept     = wr_valid & wr_ready;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    unit_n  = unit_q;
    wide_n  = wide_q;
    ratio_n = ratio_q;
    load_o  = 1'b0;
    adv_o   = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (accept) begin
          state_n = SEQ_LOW;
          cnt_n   = '0;
          unit_n  = 1'b0;
          wide_n  = wide_mode;
          ratio_n = clk_ratio;
          load_o  = 1'b1;
        end
      end
      SEQ_LOW: begin
        state_n = SEQ_HIGH;
      end
      SEQ_HIGH: begin
        if (!last_pulse) begin
          cnt_n   = cnt_q + CNT_W'(1);
          state_n = SEQ_LOW;
        end else if (!last_unit) begin
          cnt_n   = '0;
          unit_n  = 1'b1;
          adv_o   = 1'b1;
          state_n = SEQ_LOW;
        end else begin
          state_n = SEQ_IDLE;
        end
      end
      default: state_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      unit_q  <= 1'b0;
      wide_q  <= 1'b0;
      ratio_q <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      unit_q  <= unit_n;
      if (load_o) begin
        wide_q  <= wide_n;
        ratio_q <= ratio_n;
      end
    end
  end

  assign busy_o       = (state_q != SEQ_IDLE);
  assign state_next_o = state_n;

  // R7: no new word is offered acceptance while one is in flight
  a_r7_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !wr_ready);

  // R8: captured settings stay fixed for the whole word
  a_r8_settings_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(wide_q) && $stable(ratio_q)));

  // R4: the second unit only exists in narrow mode
  a_r4_adv_narrow_only: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |-> !wide_q);

endmodule

// File: rtl/cda_datapath.sv
`timescale 1ns/1ps
module cda_datapath #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              wide_mode,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] dev_data
);

  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] out_q, out_n;
  logic [HALF_W-1:0] hi_q;

  always_comb begin
    out_n = out_q;
    if (load_i) begin
      out_n = wide_mode ? wr_data : {{HALF_W{1'b0}}, wr_data[HALF_W-1:0]};
    end else if (adv_i) begin
      out_n = {{HALF_W{1'b0}}, hi_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      hi_q  <= '0;
    end else begin
      if (load_i || adv_i) out_q <= out_n;
      if (load_i)          hi_q  <= wr_data[WORD_W-1:HALF_W];
    end
  end

  assign dev_data = out_q;

  // R4: the second unit carries zeros in its upper half
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (dev_data[WORD_W-1:HALF_W] == '0));

  // R10: data only moves on a load or a unit advance
  a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(dev_data));

endmodule

// File: rtl/cda_clkgen.sv
`timescale 1ns/1ps
module cda_clkgen
  import cda_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state_next_i,
  output logic       dev_clk
);

  logic clk_q, clk_n;

  assign clk_n = (state_next_i == SEQ_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_q <= 1'b0;
    else        clk_q <= clk_n;
  end

  assign dev_clk = clk_q;

  // R6: each high phase lasts exactly one cycle
  a_r6_single_high: assert property (@(posedge clk) disable iff (!rst_n)
    dev_clk |=> !dev_clk);

endmodule

// File: rtl/cfg_width_adapter.sv
`timescale 1ns/1ps
module cfg_width_adapter
  import cda_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_cfg_en,
  input  logic               wide_mode,
  input  logic [RATIO_W-1:0] clk_ratio,
  input  logic               wr_valid,
  input  logic [WORD_W-1:0]  wr_data,
  output logic               wr_ready,
  output logic               dev_clk,
  output logic [WORD_W-1:0]  dev_data
);

  localparam int MAX_SHIFT = (1 << RATIO_W) - 1;
  localparam int CHK_W     = MAX_SHIFT + 2;

  logic       load;
  logic       adv;
  logic       busy;
  seq_state_e state_next;

  cda_sequencer #(.RATIO_W(RATIO_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_cfg_en   (bus_cfg_en),
    .wr_valid     (wr_valid),
    .wide_mode    (wide_mode),
    .clk_ratio    (clk_ratio),
    .wr_ready     (wr_ready),
    .load_o       (load),
    .adv_o        (adv),
    .busy_o       (busy),
    .state_next_o (state_next)
  );

  cda_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .adv_i     (adv),
    .wide_mode (wide_mode),
    .wr_data   (wr_data),
    .dev_data  (dev_data)
  );

  cda_clkgen u_clk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_next_i (state_next),
    .dev_clk      (dev_clk)
  );

  // Pulse-count checker: rising edges per word against captured settings
  logic [CHK_W-1:0]   chk_cnt;
  logic               chk_wide;
  logic [RATIO_W-1:0] chk_ratio;
  logic               chk_clk_d;
  logic [CHK_W-1:0]   chk_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_cnt   <= '0;
      chk_wide  <= 1'b0;
      chk_ratio <= '0;
      chk_clk_d <= 1'b0;
    end else begin
      chk_clk_d <= dev_clk;
      if (load) begin
        chk_cnt   <= '0;
        chk_wide  <= wide_mode;
        chk_ratio <= clk_ratio;
      end else if (dev_clk && !chk_clk_d) begin
        chk_cnt <= chk_cnt + CHK_W'(1);
      end
    end
  end

  assign chk_exp = CHK_W'(1) << (int'(chk_ratio) + (chk_wide ? 0 : 1));

  // R5: pulses per word equal units x (1 << ratio)
  a_r5_pulse_total: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chk_cnt == chk_exp));

  // R6: data is settled whenever the device clock is high
  a_r6_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    dev_clk |-> $stable(dev_data));

  // R2: acceptance requires the bus enable
  a_r2_ready_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> bus_cfg_en);

  // R10: the device clock rests low while idle
  a_r10_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !dev_clk);

endmodule

// File: tb/tb_cfg_width_adapter.sv
`timescale 1ns/1ps
module tb_cfg_width_adapter;

  logic        clk;
  logic        rst_n;
  logic        bus_cfg_en;
  logic        wide_mode;
  logic [1:0]  clk_ratio;
  logic        wr_valid;
  logic [31:0] wr_data;
  logic        wr_ready;
  logic        dev_clk;
  logic [31:0] dev_data;

  int tests;
  int fails;
  bit done;

  cfg_width_adapter dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_cfg_en (bus_cfg_en),
    .wide_mode  (wide_mode),
    .clk_ratio  (clk_ratio),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .wr_ready   (wr_ready),
    .dev_clk    (dev_clk),
    .dev_data   (dev_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int pulses_of(input logic [1:0] r);
    return 1 << r;
  endfunction

  function automatic int units_of(input bit w);
    return w ? 1 : 2;
  endfunction

  function automatic logic [31:0] unit_val(input logic [31:0] d, input bit w, input int u);
    if (w)        return d;
    else if (u == 0) return {16'h0, d[15:0]};
    else          return {16'h0, d[31:16]};
  endfunction

  // mode 0: plain, 1: settings flipped mid-word (R8), 2: enable dropped mid-word (R9)
  task automatic run_word(input logic [31:0] d, input bit w, input logic [1:0] r, input int mode);
    int n, u, total, rises, data_bad, ready_bad, stab_bad;
    logic prev_clk;
    logic [31:0] prev_data, last_exp;
    string rq;
    n = pulses_of(r);
    u = units_of(w);
    total = 2 * n * u;
    rises = 0; data_bad = 0; ready_bad = 0; stab_bad = 0;
    rq = w ? "R3" : "R4";
    @(negedge clk);
    bus_cfg_en = 1'b1; wide_mode = w; clk_ratio = r; wr_data = d; wr_valid = 1'b1;
    #1;
    chk(wr_ready == 1'b1, "R2 ready when enabled and idle", {31'h0, wr_ready}, 32'h1);
    @(negedge clk);
    wr_valid = 1'b0;
    wr_data = $urandom;
    prev_clk = 1'b0;
    prev_data = dev_data;
    last_exp = unit_val(d, w, u - 1);
    for (int k = 0; k < total; k++) begin
      if (k == 1 && mode == 1) begin
        wide_mode = ~w;
        clk_ratio = r ^ 2'b11;
      end
      if (k == 1 && mode == 2) bus_cfg_en = 1'b0;
      if (wr_ready) ready_bad++;
      if (dev_clk && !prev_clk) begin
        if (dev_data != unit_val(d, w, rises / n)) begin
          data_bad++;
          $display("FAIL %s unit %0d actual=%h expected=%h", rq, rises / n, dev_data, unit_val(d, w, rises / n));
        end
        rises++;
      end
      if (dev_clk && dev_data != prev_data) stab_bad++;
      prev_clk = dev_clk;
      prev_data = dev_data;
      @(negedge clk);
    end
    tests++;
    if (data_bad != 0) fails++;
    chk(rises == n * u, (mode == 1) ? "R8 pulse count with settings flipped" :
                        (mode == 2) ? "R9 pulse count with enable dropped" : "R5 pulse count",
        rises, n * u);
    chk(ready_bad == 0, "R7 ready low through word", ready_bad, 0);
    chk(stab_bad == 0, "R6 data stable while clock high", stab_bad, 0);
    chk(dev_clk == 1'b0, "R10 clock rests low", {31'h0, dev_clk}, 32'h0);
    chk(dev_data == last_exp, "R10 last unit held", dev_data, last_exp);
    if (mode == 2)
      chk(wr_ready == 1'b0, "R9 blocked after enable drop", {31'h0, wr_ready}, 32'h0);
    else
      chk(wr_ready == 1'b1, "R7 ready returns after word", {31'h0, wr_ready}, 32'h1);
    bus_cfg_en = 1'b1;
    wide_mode = w;
  endtask

  initial begin
    logic [31:0] held;
    tests = 0; fails = 0; done = 1'b0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_cfg_en = 1'b1; wide_mode = 1'b0; clk_ratio = 2'd0;
    wr_valid = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk(dev_clk == 1'b0, "R1 reset clock", {31'h0, dev_clk}, 32'h0);
    chk(dev_data == 32'h0, "R1 reset data", dev_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ready == 1'b1, "R1 idle after reset", {31'h0, wr_ready}, 32'h1);

    // R2: enable low blocks acceptance
    run_word(32'hCAFE_F00D, 1'b1, 2'd0, 0);
    held = dev_data;
    bus_cfg_en = 1'b0; wr_valid = 1'b1; wr_data = 32'h1234_5678;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(wr_ready == 1'b0, "R2 ready low when disabled", {31'h0, wr_ready}, 32'h0);
      chk(dev_clk == 1'b0, "R2 no pulses when disabled", {31'h0, dev_clk}, 32'h0);
      chk(dev_data == held, "R2 data unchanged when disabled", dev_data, held);
    end
    wr_valid = 1'b0; bus_cfg_en = 1'b1;

    // R3/R4/R5: every width and ratio
    for (int r = 0; r < 4; r++) run_word(32'hA5C3_0000 | r, 1'b1, 2'(r), 0);
    for (int r = 0; r < 4; r++) run_word(32'hBEEF_1200 | r, 1'b0, 2'(r), 0);
    run_word(32'hFFFF_0000, 1'b0, 2'd3, 0);
    run_word(32'h0000_FFFF, 1'b0, 2'd1, 0);

    // R8/R9: mid-word changes
    run_word(32'h1357_9BDF, 1'b0, 2'd1, 1);
    run_word(32'h2468_ACE0, 1'b1, 2'd2, 1);
    run_word(32'h0F0F_F0F0, 1'b0, 2'd2, 2);
    run_word(32'h7777_8888, 1'b1, 2'd0, 2);

    // Random words
    for (int i = 0; i < 40; i++)
      run_word($urandom, 1'($urandom), 2'($urandom), int'($urandom % 3));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule